// File: doc/BRIEF.md
# Interrupt Priority and Vector Unit

This block sits beside the sequencer of an 8-bit processor and decides, on each boundary the sequencer reports, whether the processor should release its bus, service a non-maskable interrupt, service a maskable interrupt, or carry on. The sequencer pulses a machine-cycle-end strobe and an instruction-end strobe. The unit answers one clock later with a code for the winning request and the address where execution should continue. For one maskable mode, it raises a flag in place of an address to say that the acknowledge byte must be executed as an opcode.

The non-maskable input is edge sensitive. A falling edge is held in a latch until the next instruction boundary, whatever the state of the enable flip-flop. The maskable input is a level, and it is honoured only when the enable flip-flop is set.

Three maskable modes are supported:
- **Opcode mode:** the acknowledge byte is executed as an opcode.
- **Fixed mode:** execution continues at a fixed address.
- **Table mode:** a table pointer is formed from a vector register byte and the device byte.

Pushing the return address and reading the vector table are left to the rest of the processor. Reset has to stay low for a minimum number of clocks before it acts.

Top module: `intArbiter`

## Requirements
- R1: Once `rstN` has been sampled low on RST_HOLD (default 3) consecutive rising edges, the enable flip-flop clears, the mode becomes opcode mode (0), and the NMI latch clears. A low pulse seen on fewer edges leaves the enable flip-flop and the mode unchanged.
- R2: The `takenKind` encoding is 0 for none, 1 for bus, 2 for NMI and 3 for INT, and each take is shown for exactly one cycle, starting one clock after the deciding edge. When requests coincide, bus request wins over NMI, and NMI wins over INT.
- R3: A low `busReqN` is granted only on an edge where `cycleEnd` is high. The grant does not depend on `instrEnd` or on the enable flip-flop, and `jumpTgt` reads 0 with it.
- R4: A falling edge on `nmiN` is latched. The latch is taken on the next `instrEnd` even when the enable flip-flop is clear, and the take gives a target of 0x0066 and clears the latch. Holding `nmiN` low does not produce another take.
- R5: INT is taken only on an edge where `intN` is low, `instrEnd` is high and the enable flip-flop is set.
- R6: In mode 0, a taken INT sets `execOpcode` to 1 and `jumpTgt` to 0.
- R7: In mode 1, a taken INT gives a target of 0x0038 with `execOpcode` at 0, whatever the value of `ackData`.
- R8: In mode 2, a taken INT gives `jumpTgt` = {`vecReg`, `ackData`} as sampled on the deciding edge.
- R9: `eiCmd` sets the enable flip-flop and `diCmd` clears it, with `diCmd` winning if both are high. Taking an NMI or an INT clears the flip-flop, and this wins over `eiCmd` on the same edge. A change is visible on `iffState` one clock after the edge.
- R10: `modeSet` loads `modeSel` when its value is 0, 1 or 2. The value 3 is ignored.
- R11: While `rstN` is low, no request is taken, and on the next edge `takenKind` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; acts once held for RST_HOLD edges |
| busReqN | input | 1 | Active-low bus request |
| nmiN | input | 1 | Active-low non-maskable interrupt, falling-edge sensitive |
| intN | input | 1 | Active-low maskable interrupt, level sensitive |
| instrEnd | input | 1 | Instruction-boundary strobe |
| cycleEnd | input | 1 | Machine-cycle-boundary strobe |
| eiCmd | input | 1 | Set the enable flip-flop |
| diCmd | input | 1 | Clear the enable flip-flop |
| modeSet | input | 1 | Load the interrupt mode from modeSel |
| modeSel | input | 2 | Requested mode (0, 1, 2) |
| vecReg | input | DATA_W | Interrupt vector register, high byte of the table pointer |
| ackData | input | DATA_W | Byte read in the acknowledge cycle |
| takenKind | output | 2 | Taken request: 0 none, 1 bus, 2 NMI, 3 INT |
| jumpTgt | output | 2*DATA_W | Continuation address or table pointer |
| execOpcode | output | 1 | The acknowledge byte is to be executed as an opcode |
| iffState | output | 1 | Enable flip-flop state |

## Verification
The bench applies simultaneous requests, so that a priority inverted between bus, NMI and INT shows up as a wrong code. It then holds `nmiN` low across several instruction boundaries to catch a level-triggered NMI, which would fire repeatedly. A clear enable flip-flop combined with a pending NMI catches a design that wrongly masks the NMI. `eiCmd` is raised on the same edge as a take, and `eiCmd` with `diCmd`, to catch wrong precedence in the flip-flop. A mode code of 3 catches a decoder that corrupts the mode. A two-clock reset pulse catches a reset that acts too early, and bus requests made during reset catch a design that grants while held.

// File: rtl/intArbPkg.sv
package intArbPkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_BUS  = 2'd1,
    KIND_NMI  = 2'd2,
    KIND_INT  = 2'd3
  } takenKind_e;

  typedef enum logic [1:0] {
    MODE_OPCODE = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_TABLE  = 2'd2
  } intMode_e;

  localparam logic [15:0] NMI_ADDR   = 16'h0066;
  localparam logic [15:0] FIXED_ADDR = 16'h0038;

  // strobes from control to datapath
  typedef struct packed {
    logic     takeBus;
    logic     takeNmi;
    logic     takeInt;
    intMode_e mode;
  } ctlStrobe_t;
endpackage

// File: rtl/intArbCtrl.sv
module intArbCtrl
  import intArbPkg::*;
#(
  parameter int RST_HOLD = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReqN,
  input  logic       nmiN,
  input  logic       intN,
  input  logic       instrEnd,
  input  logic       cycleEnd,
  input  logic       eiCmd,
  input  logic       diCmd,
  input  logic       modeSet,
  input  logic [1:0] modeSel,
  output ctlStrobe_t strobe,
  output logic       iffState
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [HOLD_W-1:0] holdCnt;
  logic              rstHit;
  logic              nmiPrev;
  logic              nmiPend;
  logic              iffReg;
  intMode_e          modeReg;
  logic              nmiFall;
  logic              busWin;
  logic              nmiWin;
  logic              intWin;
  logic              modeLegal;

  always_comb begin
    rstHit    = !rstN && (holdCnt == HOLD_W'(RST_HOLD - 1));
    nmiFall   = nmiPrev && !nmiN;
    busWin    = rstN && !busReqN && cycleEnd;
    nmiWin    = rstN && !busWin && instrEnd && nmiPend;
    intWin    = rstN && !busWin && !nmiWin && instrEnd && !intN && iffReg;
    modeLegal = (modeSel != 2'd3);
  end

  // qualify reset: it acts only after enough consecutive low edges
  always_ff @(posedge clk) begin
    if (rstN) begin
      holdCnt <= '0;
    end else if (!rstHit) begin
      holdCnt <= holdCnt + HOLD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rstHit) begin
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
      iffReg  <= 1'b0;
      modeReg <= MODE_OPCODE;
    end else if (rstN) begin
      nmiPrev <= nmiN;
      if (nmiFall) begin
        nmiPend <= 1'b1;
      end else if (nmiWin) begin
        nmiPend <= 1'b0;
      end
      if (nmiWin || intWin) begin
        iffReg <= 1'b0;
      end else if (diCmd) begin
        iffReg <= 1'b0;
      end else if (eiCmd) begin
        iffReg <= 1'b1;
      end
      if (modeSet && modeLegal) begin
        modeReg <= intMode_e'(modeSel);
      end
    end
  end

  assign strobe.takeBus = busWin;
  assign strobe.takeNmi = nmiWin;
  assign strobe.takeInt = intWin;
  assign strobe.mode    = modeReg;
  assign iffState       = iffReg;
endmodule

// File: rtl/intArbPath.sv
module intArbPath
  import intArbPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  ctlStrobe_t            strobe,
  input  logic [DATA_W-1:0]     vecReg,
  input  logic [DATA_W-1:0]     ackData,
  output logic [1:0]            takenKind,
  output logic [2*DATA_W-1:0]   jumpTgt,
  output logic                  execOpcode
);
  localparam int ADDR_W = 2 * DATA_W;

  takenKind_e kindReg;

  always_ff @(posedge clk) begin
    kindReg    <= KIND_NONE;
    jumpTgt    <= '0;
    execOpcode <= 1'b0;
    if (strobe.takeBus) begin
      kindReg <= KIND_BUS;
    end else if (strobe.takeNmi) begin
      kindReg <= KIND_NMI;
      jumpTgt <= ADDR_W'(NMI_ADDR);
    end else if (strobe.takeInt) begin
      kindReg <= KIND_INT;
      case (strobe.mode)
        MODE_OPCODE: execOpcode <= 1'b1;
        MODE_TABLE:  jumpTgt    <= {vecReg, ackData};
        default:     jumpTgt    <= ADDR_W'(FIXED_ADDR);
      endcase
    end
  end

  assign takenKind = kindReg;
endmodule

// File: rtl/intArbiter.sv
module intArbiter
  import intArbPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RST_HOLD = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReqN,
  input  logic                nmiN,
  input  logic                intN,
  input  logic                instrEnd,
  input  logic                cycleEnd,
  input  logic                eiCmd,
  input  logic                diCmd,
  input  logic                modeSet,
  input  logic [1:0]          modeSel,
  input  logic [DATA_W-1:0]   vecReg,
  input  logic [DATA_W-1:0]   ackData,
  output logic [1:0]          takenKind,
  output logic [2*DATA_W-1:0] jumpTgt,
  output logic                execOpcode,
  output logic                iffState
);
  ctlStrobe_t strobe;

  intArbCtrl #(.RST_HOLD(RST_HOLD)) ctrl (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .nmiN(nmiN), .intN(intN),
    .instrEnd(instrEnd), .cycleEnd(cycleEnd), .eiCmd(eiCmd), .diCmd(diCmd),
    .modeSet(modeSet), .modeSel(modeSel), .strobe(strobe), .iffState(iffState)
  );

  intArbPath #(.DATA_W(DATA_W)) path (
    .clk(clk), .strobe(strobe), .vecReg(vecReg), .ackData(ackData),
    .takenKind(takenKind), .jumpTgt(jumpTgt), .execOpcode(execOpcode)
  );
endmodule

// File: rtl/intArbChecker.sv
module intArbChecker #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busReqN,
  input logic                intN,
  input logic                instrEnd,
  input logic                cycleEnd,
  input logic [DATA_W-1:0]   vecReg,
  input logic [DATA_W-1:0]   ackData,
  input logic [1:0]          takenKind,
  input logic [2*DATA_W-1:0] jumpTgt,
  input logic                execOpcode,
  input logic                iffState
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!rstN) armed <= 1'b1;

  AST_INT_LOSES_TO_BUS: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (takenKind == 2'd3) |-> ($past(busReqN) || !$past(cycleEnd))); // R2
  AST_BUS_ON_CYCLE_END: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (takenKind == 2'd1) |-> ($past(cycleEnd) && !$past(busReqN) && jumpTgt == '0)); // R3
  AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (takenKind == 2'd2) |-> (jumpTgt == (2*DATA_W)'(16'h0066) && !iffState)); // R4
  AST_INT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (takenKind == 2'd3) |-> ($past(iffState) && !$past(intN) && $past(instrEnd) && !iffState)); // R5
  AST_OPCODE_FLAG: assert property (@(posedge clk) disable iff (!rstN || !armed)
    execOpcode |-> (takenKind == 2'd3 && jumpTgt == '0)); // R6
  AST_TABLE_POINTER: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (takenKind == 2'd3 && !execOpcode && jumpTgt != (2*DATA_W)'(16'h0038))
      |-> (jumpTgt == {$past(vecReg), $past(ackData)})); // R8
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!armed)
    (!rstN) |=> (takenKind == 2'd0)); // R11
endmodule

bind intArbiter intArbChecker #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .busReqN(busReqN), .intN(intN), .instrEnd(instrEnd),
  .cycleEnd(cycleEnd), .vecReg(vecReg), .ackData(ackData), .takenKind(takenKind),
  .jumpTgt(jumpTgt), .execOpcode(execOpcode), .iffState(iffState)
);

// File: tb/tb_intArbiter.sv
`timescale 1ns/1ps
module tb_intArbiter;
  localparam int DATA_W   = 8;
  localparam int RST_HOLD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b1, busReqN = 1'b1, nmiN = 1'b1, intN = 1'b1;
  logic instrEnd = 1'b0, cycleEnd = 1'b0, eiCmd = 1'b0, diCmd = 1'b0, modeSet = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [7:0] vecReg = 8'h00, ackData = 8'h00;
  logic [1:0] takenKind;
  logic [15:0] jumpTgt;
  logic execOpcode, iffState;

  always #10 clk = ~clk;

  intArbiter #(.DATA_W(DATA_W), .RST_HOLD(RST_HOLD)) dut (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .nmiN(nmiN), .intN(intN),
    .instrEnd(instrEnd), .cycleEnd(cycleEnd), .eiCmd(eiCmd), .diCmd(diCmd),
    .modeSet(modeSet), .modeSel(modeSel), .vecReg(vecReg), .ackData(ackData),
    .takenKind(takenKind), .jumpTgt(jumpTgt), .execOpcode(execOpcode), .iffState(iffState)
  );

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  bit armed = 0;

  // behavioural reference
  int mHold = 0;
  bit mIff = 0, mPend = 0, mPrev = 1;
  int mMode = 0;
  int eKind = 0, eTgt = 0;
  bit eOp = 0;

  always @(posedge clk) begin
    bit fall;
    if (rstN) mHold = 0;
    eKind = 0; eTgt = 0; eOp = 0;
    if (!rstN) begin
      if (mHold == RST_HOLD - 1) begin
        mIff = 0; mPend = 0; mPrev = 1; mMode = 0; armed = 1;
      end else begin
        mHold = mHold + 1;
      end
    end else begin
      fall = mPrev && !nmiN;
      if (!busReqN && cycleEnd) eKind = 1;
      else if (instrEnd && mPend) begin eKind = 2; eTgt = 'h66; end
      else if (instrEnd && !intN && mIff) begin
        eKind = 3;
        if (mMode == 0) eOp = 1;
        else if (mMode == 1) eTgt = 'h38;
        else eTgt = {vecReg, ackData};
      end
      if (fall) mPend = 1; else if (eKind == 2) mPend = 0;
      if (eKind >= 2) mIff = 0; else if (diCmd) mIff = 0; else if (eiCmd) mIff = 1;
      if (modeSet && modeSel != 2'd3) mMode = modeSel;
      mPrev = nmiN;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (takenKind !== eKind[1:0] || jumpTgt !== eTgt[15:0] ||
          execOpcode !== eOp || iffState !== mIff) begin
        fails++;
        $display("FAIL %s: kind=%0d tgt=%h op=%0b iff=%0b expected kind=%0d tgt=%h op=%0b iff=%0b",
                 curReq, takenKind, jumpTgt, execOpcode, iffState, eKind, eTgt[15:0], eOp, mIff);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // one clock of stimulus, then the single-cycle strobes drop
  task automatic tick();
    @(negedge clk);
    instrEnd = 0; cycleEnd = 0; eiCmd = 0; diCmd = 0; modeSet = 0;
  endtask

  task automatic setMode(input logic [1:0] m);
    modeSet = 1; modeSel = m; tick();
  endtask

  initial begin
    @(negedge clk);
    rstN = 0; curReq = "R1";
    repeat (4) tick();
    rstN = 1; tick(); tick();

    // R9: enable, then disable wins over enable
    curReq = "R9"; eiCmd = 1; tick();
    eiCmd = 1; diCmd = 1; tick();
    eiCmd = 1; tick();

    // R7: fixed mode, acknowledge byte ignored
    curReq = "R7"; setMode(2'd1);
    intN = 0; instrEnd = 1; ackData = 8'hC7; tick(); tick();
    // R5: flip-flop now clear, level still low
    curReq = "R5"; instrEnd = 1; tick();
    instrEnd = 0; tick();
    eiCmd = 1; tick();
    intN = 1; instrEnd = 1; tick();

    // R8: table mode
    curReq = "R8"; setMode(2'd2);
    vecReg = 8'h5A; ackData = 8'h3E; intN = 0; instrEnd = 1; tick(); tick();
    intN = 1;

    // R9: take wins over an enable on the same edge
    curReq = "R9"; eiCmd = 1; tick();
    intN = 0; instrEnd = 1; eiCmd = 1; ackData = 8'h10; tick(); tick();
    intN = 1;

    // R10: code 3 ignored, mode 2 kept
    curReq = "R10"; setMode(2'd3);
    eiCmd = 1; tick();
    intN = 0; instrEnd = 1; vecReg = 8'h81; ackData = 8'h22; tick(); tick();
    intN = 1;

    // R6: opcode mode
    curReq = "R6"; setMode(2'd0);
    eiCmd = 1; tick();
    intN = 0; instrEnd = 1; ackData = 8'hFF; tick(); tick();
    intN = 1;

    // R4: edge latched with flip-flop clear, then taken; held low does not retrigger
    curReq = "R4"; nmiN = 0; tick();
    tick();
    instrEnd = 1; tick(); tick();
    instrEnd = 1; tick();
    instrEnd = 1; tick();
    nmiN = 1; tick();
    // edge together with the boundary is taken on the following boundary
    nmiN = 0; instrEnd = 1; tick();
    instrEnd = 1; tick(); tick();
    nmiN = 1; tick();

    // R3: bus request without cycle end, then with it
    curReq = "R3"; busReqN = 0; instrEnd = 1; tick();
    cycleEnd = 1; tick(); tick();
    busReqN = 1;

    // R2: all three requests coincide
    curReq = "R2"; eiCmd = 1; setMode(2'd1);
    nmiN = 0; tick();
    busReqN = 0; cycleEnd = 1; instrEnd = 1; intN = 0; tick();
    busReqN = 1; instrEnd = 1; tick();
    eiCmd = 1; tick();
    instrEnd = 1; tick(); tick();
    intN = 1; nmiN = 1; tick();

    // R1: short pulse keeps state; R11: nothing taken while low
    curReq = "R1"; setMode(2'd2); eiCmd = 1; tick();
    curReq = "R11"; rstN = 0; busReqN = 0; cycleEnd = 1; tick();
    cycleEnd = 1; tick();
    rstN = 1; busReqN = 1; curReq = "R1"; tick(); tick();
    curReq = "R11"; rstN = 0; intN = 0; instrEnd = 1; tick();
    repeat (3) begin instrEnd = 1; tick(); end
    curReq = "R1"; rstN = 1; intN = 1; tick(); tick();
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule